// File: doc/BRIEF.md
# Windowed Watchdog with Coded Triggers

This block supervises a host processor from a separate slow time base. A single-cycle `tick` enable, derived from an independent oscillator of about 512 kHz, advances an internal counter. The host must service the watchdog with a trigger strobe that carries a 4-bit code. A code is accepted only when its two redundant halves are bit-wise complements. A missed or malformed service raises a one-cycle reset request. A second mode only raises a one-cycle interrupt each time its period runs out, and it never resets.

Three states drive the block. `ST_INIT` enforces the initialization deadline after power-up and after every reset request. `ST_WIN` enforces both an earliest and a latest service point. `ST_TOUT` enforces only a latest point and signals expiry with `expire_irq`. The transitions are as follows:
- ST_INIT to ST_WIN or ST_TOUT on an accepted trigger.
- ST_WIN to ST_WIN, or ST_TOUT to ST_TOUT, on an accepted trigger, which restarts the count. An accepted trigger in either of these states may also move to the other running state.
- ST_TOUT to ST_TOUT on expiry, which raises the interrupt.
- Any state to ST_INIT on failure: a bad code, an early trigger in ST_WIN, or a deadline missed in ST_INIT or ST_WIN.

The mode, period code, column and watchdog-off inputs are sampled only when a trigger is accepted. The period comes from one of two columns: the fast column for active operation and the slow column for low-power operation. The tick count of a period is its length in units multiplied by `UNIT_TICKS`.

Top module: `wdt_window_core`

## Requirements
- R1: After `rst_n` is released, `rst_req` and `expire_irq` are low and the block is in ST_INIT with a zero count.
- R2: A trigger is valid only when `trig_code[3:2]` equals the inverse of `trig_code[1:0]`, so the valid codes are 0011, 0110, 1001 and 1100. An invalid code in any state raises `rst_req` in the cycle after the strobe.
- R3: In ST_INIT, after power-up or after a reset request, `rst_req` pulses if no valid trigger arrives within `INIT_UNITS*UNIT_TICKS` ticks. The pulse is visible after the clock edge that consumes the last tick.
- R4: In ST_WIN, a valid trigger taken while the count is below half the period raises `rst_req` and returns the block to ST_INIT.
- R5: In ST_WIN, a valid trigger taken at or after half the period is accepted without a reset and restarts the count from zero.
- R6: In ST_WIN, when the full period elapses without service, `rst_req` pulses after the edge that consumes the last tick.
- R7: In ST_TOUT, a valid trigger is accepted at any count. When the period elapses, `expire_irq` pulses for one cycle and the count restarts without a reset.
- R8: The period in units is selected by `period_sel` 0 to 7. With `slow_col`=0 the values are 20, 40, 80, 160, 320, 640, 1024 and 2048. With `slow_col`=1 they are 160, 320, 640, 1024, 2048, 3072, 4096 and 28672.
- R9: If `wd_off` is high at an accepted trigger, the block runs in ST_TOUT with the longest period of the selected column, whatever `win_sel` and `period_sel` are.
- R10: Changes to `win_sel`, `slow_col`, `period_sel` and `wd_off` take effect only at the next accepted trigger.
- R11: The count advances only in cycles where `tick` is high.
- R12: `rst_req` and `expire_irq` are never high together, and a reset request always leaves the block in ST_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable from the watchdog oscillator |
| trig | input | 1 | Service strobe |
| trig_code | input | 4 | Redundant service code |
| win_sel | input | 1 | 1 selects window servicing, 0 selects time-out servicing |
| slow_col | input | 1 | 1 selects the low-power period column |
| period_sel | input | 3 | Period code |
| wd_off | input | 1 | Watchdog off: longest period, time-out behaviour |
| rst_req | output | 1 | One-cycle system reset request |
| expire_irq | output | 1 | One-cycle period-expired interrupt |

## Verification
A wrong count or a wrong period lookup moves the reset or interrupt pulse by a measurable number of cycles. The bench measures the exact edge count from each accepted trigger to each pulse. A wrong state shows up either as a reset where only an interrupt is allowed, or as an early trigger that is accepted when it should fail. Either error appears at the first pulse after the fault. A cycle-level reference model runs alongside random traffic and compares both outputs in every cycle, so any divergence is flagged within one clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_WIN  = 2'd1,
        ST_TOUT = 2'd2
    } wdt_state_e;

    localparam int unsigned LONGEST_UNITS = 28672;

    typedef struct packed {
        logic       slow;
        logic [2:0] sel;
        logic       off;
    } wdt_cfg_t;

    // R8/R9: period length in units; off forces the longest entry of the column
    function automatic logic [14:0] period_units(input logic slow, input logic [2:0] sel,
                                                 input logic off);
        logic [2:0] s;
        s = off ? 3'd7 : sel;
        if (!slow) begin
            case (s)
                3'd0: return 15'd20;
                3'd1: return 15'd40;
                3'd2: return 15'd80;
                3'd3: return 15'd160;
                3'd4: return 15'd320;
                3'd5: return 15'd640;
                3'd6: return 15'd1024;
                default: return 15'd2048;
            endcase
        end else begin
            case (s)
                3'd0: return 15'd160;
                3'd1: return 15'd320;
                3'd2: return 15'd640;
                3'd3: return 15'd1024;
                3'd4: return 15'd2048;
                3'd5: return 15'd3072;
                3'd6: return 15'd4096;
                default: return 15'd28672;
            endcase
        end
    endfunction

endpackage

// File: rtl/wdt_code_check.sv
module wdt_code_check (
    input  logic [3:0] code,
    output logic       ok
);
    // R2: redundant halves must be complements
    assign ok = (code[3:2] == ~code[1:0]);
endmodule

// File: rtl/wdt_period_lut.sv
module wdt_period_lut import wdt_pkg::*; #(
    parameter int unsigned UNIT_TICKS = 512,
    parameter int unsigned CNT_W      = 24
) (
    input  logic             slow,
    input  logic [2:0]       sel,
    input  logic             off,
    output logic [CNT_W-1:0] lim_ticks
);
    logic [14:0] units;
    assign units     = period_units(slow, sel, off);
    assign lim_ticks = CNT_W'(units) * CNT_W'(UNIT_TICKS);
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/wdt_window_core.sv
module wdt_window_core import wdt_pkg::*; #(
    parameter int unsigned UNIT_TICKS = 512,
    parameter int unsigned INIT_UNITS = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       trig,
    input  logic [3:0] trig_code,
    input  logic       win_sel,
    input  logic       slow_col,
    input  logic [2:0] period_sel,
    input  logic       wd_off,
    output logic       rst_req,
    output logic       expire_irq
);
    localparam int unsigned MAX_UNITS = (INIT_UNITS > LONGEST_UNITS) ? INIT_UNITS : LONGEST_UNITS;
    localparam int unsigned MAX_TICKS = MAX_UNITS * UNIT_TICKS;
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] INIT_LIM = CNT_W'(INIT_UNITS * UNIT_TICKS);

    wdt_state_e       st_q, st_d;
    wdt_cfg_t         cfg_q;
    logic [CNT_W-1:0] cnt, run_lim, lim, half;
    logic             code_good, accept, fail, irq, clr, inc;

    wdt_code_check u_code (.code(trig_code), .ok(code_good));

    wdt_period_lut #(.UNIT_TICKS(UNIT_TICKS), .CNT_W(CNT_W)) u_lut (
        .slow(cfg_q.slow), .sel(cfg_q.sel), .off(cfg_q.off), .lim_ticks(run_lim)
    );

    wdt_tick_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .count(cnt)
    );

    assign lim  = (st_q == ST_INIT) ? INIT_LIM : run_lim;
    assign half = lim >> 1;

    // Transition logic
    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        fail   = 1'b0;
        irq    = 1'b0;
        clr    = 1'b0;
        inc    = 1'b0;
        if (trig) begin
            if (!code_good) begin
                fail = 1'b1;
            end else if (st_q == ST_WIN && cnt < half) begin
                fail = 1'b1;
            end else begin
                accept = 1'b1;
                clr    = 1'b1;
                st_d   = (wd_off || !win_sel) ? ST_TOUT : ST_WIN;
            end
        end else if (tick) begin
            if (cnt == lim - 1'b1) begin
                unique case (st_q)
                    ST_TOUT: begin irq = 1'b1; clr = 1'b1; end
                    ST_INIT, ST_WIN: fail = 1'b1;
                    default: fail = 1'b1;
                endcase
            end else begin
                inc = 1'b1;
            end
        end
        if (fail) begin
            clr  = 1'b1;
            st_d = ST_INIT;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_INIT;
            cfg_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) cfg_q <= '{slow: slow_col, sel: period_sel, off: wd_off};
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req    <= 1'b0;
            expire_irq <= 1'b0;
        end else begin
            rst_req    <= fail;
            expire_irq <= irq;
        end
    end

    a_r2_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !code_good) |=> rst_req);
    a_r4_early_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WIN && trig && code_good && cnt < half) |=> rst_req);
    a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < lim);
    a_r7_irq_in_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        expire_irq |-> st_q == ST_TOUT);
    a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !trig) |=> $stable(cnt));
    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && expire_irq));
    a_r12_back_to_init: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> st_q == ST_INIT);

endmodule

// File: tb/wdt_window_core_bench.sv
module wdt_window_core_bench;
    localparam int UT    = 2;
    localparam int IUNIT = 50;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick = 1'b0, trig = 1'b0;
    logic [3:0] trig_code = 4'd0;
    logic win_sel = 1'b0, slow_col = 1'b0, wd_off = 1'b0;
    logic [2:0] period_sel = 3'd0;
    logic rst_req, expire_irq;

    int vectors = 0, miscompares = 0;
    bit running = 1'b0;

    always #4 clk = ~clk;

    wdt_window_core #(.UNIT_TICKS(UT), .INIT_UNITS(IUNIT)) u_wdt_window_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig), .trig_code(trig_code),
        .win_sel(win_sel), .slow_col(slow_col), .period_sel(period_sel), .wd_off(wd_off),
        .rst_req(rst_req), .expire_irq(expire_irq)
    );

    function automatic bit f_code_ok(input logic [3:0] c);
        return c[3:2] == ~c[1:0];
    endfunction

    function automatic int f_units(input bit slow, input int sel, input bit off);
        int fast_t [8] = '{20, 40, 80, 160, 320, 640, 1024, 2048};
        int slow_t [8] = '{160, 320, 640, 1024, 2048, 3072, 4096, 28672};
        int s = off ? 7 : sel;
        return slow ? slow_t[s] : fast_t[s];
    endfunction

    // Reference model: 0 init, 1 window, 2 time-out
    int m_st, m_cnt, m_sel;
    bit m_slow, m_off, m_rst, m_irq;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_sel = 0; m_slow = 0; m_off = 0; m_rst = 0; m_irq = 0;
        end else begin
            int lim;
            bit f, q;
            lim = (m_st == 0) ? IUNIT * UT : f_units(m_slow, m_sel, m_off) * UT;
            f = 0; q = 0;
            if (trig) begin
                if (!f_code_ok(trig_code)) f = 1;
                else if (m_st == 1 && m_cnt < lim / 2) f = 1;
                else begin
                    m_cnt = 0; m_st = (wd_off || !win_sel) ? 2 : 1;
                    m_slow = slow_col; m_sel = period_sel; m_off = wd_off;
                end
            end else if (tick) begin
                if (m_cnt == lim - 1) begin
                    if (m_st == 2) begin q = 1; m_cnt = 0; end
                    else f = 1;
                end else m_cnt++;
            end
            if (f) begin m_st = 0; m_cnt = 0; end
            m_rst = f; m_irq = q;
        end
    end

    always @(negedge clk) begin
        if (rst_n && running) begin
            vectors++;
            if (rst_req !== m_rst || expire_irq !== m_irq) begin
                miscompares++;
                $display("FAIL R12 model compare: rst_req=%0b irq=%0b expected rst_req=%0b irq=%0b",
                         rst_req, expire_irq, m_rst, m_irq);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_trig(input logic [3:0] c);
        trig = 1'b1; trig_code = c;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input bit alt, input bit want_irq, output int n);
        n = 0;
        forever begin
            tick = alt ? (n % 2 == 0) : 1'b1;
            @(negedge clk);
            n++;
            if (want_irq ? expire_irq : rst_req) break;
            if (n >= 70000) break;
        end
        tick = 1'b1;
    endtask

    task automatic cfg(input bit w, input bit s, input int p, input bit o);
        win_sel = w; slow_col = s; period_sel = 3'(p); wd_off = o;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: bench hung, actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int n;
        logic [3:0] valid_codes [4] = '{4'b0011, 4'b0110, 4'b1001, 4'b1100};
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1; tick = 1'b1; running = 1'b1;
        chk("R1 rst_req after reset", int'(rst_req), 0);
        chk("R1 expire_irq after reset", int'(expire_irq), 0);

        measure(0, 0, n); chk("R3 init deadline after power-up", n, IUNIT * UT);
        measure(0, 0, n); chk("R3 init deadline after reset request", n, IUNIT * UT);

        cfg(1, 0, 0, 0);
        pulse_trig(4'b0011); chk("R2 valid code accepted", int'(rst_req), 0);
        idle(19); pulse_trig(4'b0110); chk("R4 early trigger resets", int'(rst_req), 1);
        pulse_trig(4'b1001);
        idle(20); pulse_trig(4'b1100); chk("R5 trigger at half accepted", int'(rst_req), 0);
        measure(0, 0, n); chk("R6 window deadline", n, 20 * UT);

        pulse_trig(4'b0101); chk("R2 invalid code in init", int'(rst_req), 1);
        pulse_trig(4'b0011);
        idle(25); pulse_trig(4'b1111); chk("R2 invalid code in window", int'(rst_req), 1);

        pulse_trig(4'b0011);
        period_sel = 3'd3;
        measure(0, 0, n); chk("R10 period change deferred", n, 20 * UT);
        pulse_trig(4'b0011);
        measure(0, 0, n); chk("R10 R8 new period after trigger", n, 160 * UT);

        cfg(0, 0, 1, 0);
        pulse_trig(4'b0110);
        measure(0, 1, n); chk("R7 time-out interrupt period", n, 40 * UT);
        chk("R7 no reset on expiry", int'(rst_req), 0);
        measure(0, 1, n); chk("R7 period restarts after interrupt", n, 40 * UT);
        idle(3); pulse_trig(4'b1001); chk("R7 early trigger fine in time-out", int'(rst_req), 0);

        cfg(0, 0, 0, 0);
        pulse_trig(4'b1100);
        measure(1, 1, n); chk("R11 count only on tick", n, 2 * 20 * UT - 1);

        cfg(0, 1, 0, 0);
        pulse_trig(4'b0011);
        measure(0, 1, n); chk("R8 slow column code 0", n, 160 * UT);
        cfg(0, 1, 5, 0);
        pulse_trig(4'b0011);
        measure(0, 1, n); chk("R8 slow column code 5", n, 3072 * UT);
        cfg(0, 0, 7, 0);
        pulse_trig(4'b0011);
        measure(0, 1, n); chk("R8 fast column code 7", n, 2048 * UT);

        cfg(1, 0, 0, 1);
        pulse_trig(4'b0110);
        idle(5); pulse_trig(4'b1001); chk("R9 off gives no early failure", int'(rst_req), 0);
        measure(0, 1, n); chk("R9 off uses longest period", n, 2048 * UT);
        chk("R9 off expiry is not a reset", int'(rst_req), 0);
        wd_off = 1'b0;

        for (int i = 0; i < 4000; i++) begin
            tick       = ($urandom % 4) != 0;
            trig       = ($urandom % 12) == 0;
            trig_code  = ($urandom % 2) ? valid_codes[$urandom % 4] : 4'($urandom % 16);
            win_sel    = 1'($urandom % 2);
            slow_col   = 1'($urandom % 2);
            period_sel = 3'($urandom % 3);
            wd_off     = ($urandom % 8) == 0;
            @(negedge clk);
        end
        trig = 1'b0;
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule